// File: doc/BRIEF.md
# Cache Event Counter Bank

This block holds four free-running counters that observe activity signals from a cache. Each counter has its own 8-bit configuration that picks one of two event tables, a code within that table, and whether reading the counter also clears it. The first table holds single-bit events: code 0 counts every clock, and codes 1 to 16 count the cycles where one strobe bit is high. The second table holds multi-valued events: code 0 means "none", and codes 1 to 8 add, each cycle, an unsigned amount from one of eight 4-bit lanes. A lane carries values such as a count of occupied buffer entries or a number of busy banks (0 to 4).

Software programs a counter with a single-cycle configuration write and samples it with a single-cycle read request. The read data appear one clock later. A configuration write never touches the count already held. When clear-on-read is set, the read returns the count and the counter starts again from that cycle's contribution, so no event is lost across the read.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset every counter holds zero, `rd_valid` is low, `rd_data` is zero, and every configuration selects "none" (table bit 1, code 0), so no counter moves until it is programmed.
- R2: A read request with `rd_en` high in cycle t raises `rd_valid` in cycle t+1 only, with `rd_data` equal to counter `rd_idx` as it stood in cycle t, before that cycle's increment.
- R3: With table bit 0 and code 0, a counter grows by exactly one on every clock.
- R4: With table bit 0 and code k (1..16), a counter grows by one in each cycle where `evt_stb[k-1]` is high.
- R5: With table bit 1 and code k (1..8), a counter grows each cycle by the unsigned 4-bit value on lane k-1, which is `evt_amt[4*(k-1)+3 : 4*(k-1)]`. This covers values above one, and bank-usage values from 0 to 4.
- R6: With table bit 1 and code 0, a counter keeps its value whatever the event inputs do.
- R7: A code outside the defined range (table bit 0 with code above 16, or table bit 1 with code above 8) counts nothing.
- R8: A configuration write (`cfg_we`, counter `cfg_idx`, with `cfg_wdata[5:0]` the code, bit 6 the table and bit 7 clear-on-read) leaves the counter's value unchanged. The new selection applies from the cycle after the write.
- R9: With clear-on-read set (`cfg_wdata` bit 7), a read returns the count, and the counter then holds only the increment of the read cycle.
- R10: With clear-on-read off, reads do not alter a counter, so back-to-back reads differ only by the events in between.
- R11: Counters are CNT_W bits wide (64 by default) and wrap to zero past their maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_stb | input | NUM_STB | Single-bit event strobes, one per code of table 0 |
| evt_amt | input | NUM_AMT*AMT_W | Packed 4-bit amount lanes for table 1 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Counter addressed by the write |
| cfg_wdata | input | CODE_W+2 | {clear-on-read, table, code} |
| rd_en | input | 1 | Read request |
| rd_idx | input | IDX_W | Counter addressed by the read |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | CNT_W | Counter value returned by the read |

## Verification
The hardest situations to reach from the ports are a clear-on-read read landing in a cycle where the same counter also takes a non-zero increment, and the wrap of a 64-bit counter. The stimulus programs cycle counting and heavy amount lanes with clear-on-read, then issues back-to-back reads so that each read cycle also carries events. A second instance with 8-bit counters runs the same stimulus for hundreds of cycles, so the wrap is reached in a short run and compared against the low bits of the same behavioural model.

// File: rtl/perf_counter_bank.sv
module perf_counter_bank #(
  parameter int NUM_CTR = 4,
  parameter int CNT_W   = 64,
  parameter int CODE_W  = 6,
  parameter int NUM_STB = 16,
  parameter int NUM_AMT = 8,
  parameter int AMT_W   = 4,
  localparam int IDX_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1,
  localparam int CFG_W  = CODE_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_STB-1:0]       evt_stb,
  input  logic [NUM_AMT*AMT_W-1:0] evt_amt,
  input  logic                     cfg_we,
  input  logic [IDX_W-1:0]         cfg_idx,
  input  logic [CFG_W-1:0]         cfg_wdata,
  input  logic                     rd_en,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic                     rd_valid,
  output logic [CNT_W-1:0]         rd_data
);
  localparam int NCODE = 2 ** CODE_W;
  localparam logic [CFG_W-1:0] CFG_RST = {1'b0, 1'b1, {CODE_W{1'b0}}};

  logic [NUM_CTR-1:0][CNT_W-1:0] cnt_q, cnt_nxt;
  logic [NUM_CTR-1:0][CFG_W-1:0] cfg_q;
  logic [NCODE-1:0]              stb_tbl;
  logic [AMT_W-1:0]              amt_tbl [NCODE];

  // table 0: slot 0 is the always-on clock event, then the strobes
  assign stb_tbl = {{(NCODE-NUM_STB-1){1'b0}}, evt_stb, 1'b1};

  // table 1: slot 0 is "none", then the amount lanes
  always_comb begin
    for (int k = 0; k < NCODE; k++) amt_tbl[k] = '0;
    for (int k = 0; k < NUM_AMT; k++) amt_tbl[k+1] = evt_amt[k*AMT_W +: AMT_W];
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic [CODE_W-1:0] code;
    logic [CNT_W-1:0]  inc;
    logic              clr;
    assign code = cfg_q[i][CODE_W-1:0];
    assign inc  = cfg_q[i][CODE_W] ? CNT_W'(amt_tbl[code]) : CNT_W'(stb_tbl[code]);
    assign clr  = rd_en && (rd_idx == IDX_W'(i)) && cfg_q[i][CFG_W-1];
    assign cnt_nxt[i] = (clr ? '0 : cnt_q[i]) + inc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      cfg_q    <= {NUM_CTR{CFG_RST}};
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      cnt_q    <= cnt_nxt;
      rd_valid <= rd_en;
      if (rd_en) rd_data <= cnt_q[rd_idx];
      for (int i = 0; i < NUM_CTR; i++)
        if (cfg_we && (cfg_idx == IDX_W'(i))) cfg_q[i] <= cfg_wdata;
    end
  end
endmodule

// File: rtl/perf_counter_bank_chk.sv
module perf_counter_bank_chk #(
  parameter int NUM_CTR = 4,
  parameter int CNT_W   = 64,
  parameter int CODE_W  = 6,
  parameter int AMT_W   = 4,
  localparam int IDX_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1,
  localparam int CFG_W  = CODE_W + 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          rd_en,
  input logic [IDX_W-1:0]              rd_idx,
  input logic                          rd_valid,
  input logic [CNT_W-1:0]              rd_data,
  input logic [NUM_CTR-1:0][CNT_W-1:0] cnt,
  input logic [NUM_CTR-1:0][CFG_W-1:0] cfg
);
  localparam logic [CNT_W-1:0] AMAX = CNT_W'(2 ** AMT_W - 1);

  // R2
  rd_valid_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R2
  rd_valid_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  // R2
  rd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_data == $past(cnt[rd_idx]));

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
    logic hit;
    assign hit = rd_en && (rd_idx == IDX_W'(i));
    // R6
    none_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[i][CODE_W] && cfg[i][CODE_W-1:0] == '0 && !hit) |=> cnt[i] == $past(cnt[i]));
    // R3
    cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg[i][CODE_W] && cfg[i][CODE_W-1:0] == '0 && !hit) |=> cnt[i] == $past(cnt[i]) + CNT_W'(1));
    // R9
    cor_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && cfg[i][CFG_W-1]) |=> cnt[i] <= AMAX);
  end
endmodule

bind perf_counter_bank perf_counter_bank_chk #(
  .NUM_CTR(NUM_CTR), .CNT_W(CNT_W), .CODE_W(CODE_W), .AMT_W(AMT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(rd_idx),
  .rd_valid(rd_valid), .rd_data(rd_data), .cnt(cnt_q), .cfg(cfg_q)
);

// File: tb/tb_perf_counter_bank.sv
module tb_perf_counter_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt_stb = '0;
  logic [31:0] evt_amt = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_idx = '0;
  logic        rd_valid, rd_valid_w;
  logic [63:0] rd_data;
  logic [7:0]  rd_data_w;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  longint unsigned m [4];
  logic [7:0]      mcfg [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_counter_bank dut (
    .clk(clk), .rst_n(rst_n), .evt_stb(evt_stb), .evt_amt(evt_amt),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data));

  perf_counter_bank #(.CNT_W(8)) dut_w (
    .clk(clk), .rst_n(rst_n), .evt_stb(evt_stb), .evt_amt(evt_amt),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(rd_valid_w), .rd_data(rd_data_w));

  task automatic chk(input bit ok, input string what, input longint unsigned act,
                     input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input bit cor, input bit tbl, input int code);
    return {cor, tbl, code[5:0]};
  endfunction

  // contribution of one counter this cycle, straight from the requirement text
  function automatic longint unsigned amount(input logic [7:0] c);
    int code = int'(c[5:0]);
    if (!c[6]) begin
      if (code == 0) return 1;
      if (code <= 16) return longint'(evt_stb[code-1]);
      return 0;
    end
    if (code >= 1 && code <= 8) return longint'(evt_amt[(code-1)*4 +: 4]);
    return 0;
  endfunction

  task automatic rnd_evt();
    evt_stb = 16'($urandom);
    evt_amt = $urandom;
    evt_amt[19:16] = 4'($urandom % 5);
  endtask

  // one clock: drive, advance model, compare after the edge
  task automatic cyc(input bit we, input int widx, input logic [7:0] wdat,
                     input bit re, input int ridx);
    bit              exp_v;
    longint unsigned exp_d;
    cfg_we = we; cfg_idx = widx[1:0]; cfg_wdata = wdat;
    rd_en = re; rd_idx = ridx[1:0];
    exp_v = re;
    exp_d = re ? m[ridx] : 0;
    for (int c = 0; c < 4; c++) begin
      longint unsigned add = amount(mcfg[c]);
      if (re && ridx == c && mcfg[c][7]) m[c] = add;
      else m[c] = m[c] + add;
    end
    if (we) mcfg[widx] = wdat;
    @(posedge clk); #1;
    chk(rd_valid == exp_v, "rd_valid", longint'(rd_valid), longint'(exp_v));
    chk(rd_valid_w == exp_v, "rd_valid narrow", longint'(rd_valid_w), longint'(exp_v));
    if (exp_v) begin
      chk(rd_data == exp_d, "rd_data", rd_data, exp_d);
      chk(rd_data_w == exp_d[7:0], "rd_data narrow", longint'(rd_data_w), longint'(exp_d[7:0]));
    end
    @(negedge clk);
    cfg_we = 1'b0; rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin rnd_evt(); cyc(0, 0, 8'h0, 0, 0); end
  endtask

  task automatic wr(input int idx, input logic [7:0] d);
    rnd_evt(); cyc(1, idx, d, 0, 0);
  endtask

  task automatic rd(input int idx);
    rnd_evt(); cyc(0, 0, 8'h0, 1, idx);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired during %s", tag);
    summary();
  end

  initial begin
    for (int c = 0; c < 4; c++) begin m[c] = 0; mcfg[c] = mk(0, 1, 0); end
    // R1: outputs during reset
    repeat (3) @(negedge clk);
    tag = "R1";
    chk(rd_valid == 1'b0, "rd_valid in reset", longint'(rd_valid), 0);
    chk(rd_data == 64'd0, "rd_data in reset", rd_data, 0);
    rst_n = 1'b1;
    idle(6);
    for (int c = 0; c < 4; c++) rd(c);

    tag = "R3";
    wr(0, mk(0, 0, 0));
    idle(25);
    rd(0);

    tag = "R4";
    wr(1, mk(0, 0, 3));
    idle(40);
    rd(1);
    wr(1, mk(0, 0, 16));
    idle(30);
    rd(1);

    tag = "R5";
    wr(2, mk(0, 1, 2));
    wr(3, mk(0, 1, 5));
    idle(40);
    rd(2);
    rd(3);
    wr(3, mk(0, 1, 8));
    idle(20);
    rd(3);

    tag = "R6";
    wr(2, mk(0, 1, 0));
    rd(2);
    idle(20);
    rd(2);

    tag = "R7";
    wr(3, mk(0, 0, 40));
    rd(3);
    idle(20);
    rd(3);
    wr(3, mk(0, 1, 20));
    idle(15);
    rd(3);
    wr(3, mk(0, 1, 9));
    idle(15);
    rd(3);
    wr(3, mk(0, 0, 17));
    idle(15);
    rd(3);

    tag = "R8";
    rd(1);
    wr(1, mk(0, 0, 0));
    rd(1);
    idle(5);
    rd(1);

    tag = "R9";
    wr(1, mk(1, 0, 0));
    idle(10);
    rd(1);
    rd(1);
    idle(3);
    rd(1);
    wr(2, mk(1, 1, 1));
    idle(12);
    evt_stb = '1; evt_amt = 32'hFFFF_FFFF;
    cyc(0, 0, 8'h0, 1, 2);
    evt_amt = 32'h7777_7777;
    cyc(0, 0, 8'h0, 1, 2);
    rd(2);

    tag = "R10";
    rd(0);
    rd(0);
    idle(4);
    rd(0);
    rd(0);

    tag = "R2";
    for (int k = 0; k < 200; k++) begin
      rnd_evt();
      cyc(($urandom % 7) == 0, int'($urandom % 4), 8'($urandom),
          ($urandom % 2) == 0, int'($urandom % 4));
    end

    tag = "R11";
    wr(0, mk(0, 0, 0));
    wr(2, mk(0, 1, 1));
    for (int k = 0; k < 12; k++) begin
      idle(50);
      rd(0);
      rd(2);
    end

    summary();
  end
endmodule